// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block gathers eight interrupt request lines, ranks them with input 0 as the most urgent, and signals the processor through a single interrupt output. Software reaches it through two byte-wide addresses. Address 0 is the command port and address 1 is the data port. A command-port write with bit 4 set opens a configuration sequence of up to four words. The meaning of each later data-port write depends on how far that sequence has progressed. Once the sequence is complete, the data port holds the mask and the command port accepts an end-of-interrupt.

When the processor acknowledges, the winning request moves into the in-service set. The block then presents a vector equal to the programmed base plus the input number. Two copies can be chained. A master whose winning input carries a slave does not supply a vector. It puts that input number on its cascade output instead. A slave answers an acknowledge only when the cascade lines carry its own identity. The `slave_mode` pin selects the role.

Top module: `intc_core`

## Requirements
- R1: A command-port write with bit 4 set starts a new configuration sequence. It clears the mask, pending and in-service registers, and the interrupt output stays low until the sequence is complete. Before the first such write, after reset, the block is unconfigured and raises no interrupt.
- R2: In the first word, bit 0 set means a fourth (mode) word follows, bit 1 set means single mode with no cascade word, and bit 3 set selects level-sensitive inputs. While the sequence is open, data-port writes go to the sequence and not to the mask.
- R3: The first data-port write after the first word sets the vector base. An acknowledged request yields vector = base + input number (modulo 256).
- R4: In cascade mode the next data-port write is the cascade word. On a master, a 1 in bit i means a slave sits on input i. On a slave, bits 2:0 give its identity.
- R5: In the mode word, bit 1 set enables automatic end-of-interrupt, so an acknowledge leaves the in-service register unchanged. The other bits of the mode word have no effect.
- R6: After configuration, data-port writes load the mask and data-port reads return it. A 1 blocks the matching input. The mask reads 0x00 after each configuration, and a value written back reads back exactly.
- R7: A command-port read returns the in-service register.
- R8: In edge mode a rising input edge sets a pending bit, which stays set until that input is acknowledged. In level mode the request follows the input level directly.
- R9: The interrupt output is high exactly when an unmasked request exists whose input number is lower than that of every in-service bit.
- R10: An acknowledge while the interrupt output is high sets the winner's in-service bit and drives `vec_valid` with the vector for that cycle only. An acknowledge at any other time changes nothing.
- R11: A command-port write of 0x20 clears the lowest-numbered in-service bit. Any other command-port write with bit 4 clear has no effect.
- R12: A master that acknowledges an input listed in its cascade word drives `cas_out` with that input number and keeps `vec_valid` low. It still sets that input's in-service bit, which stays set until the master receives its own end-of-interrupt.
- R13: A slave in cascade mode acts on an acknowledge only when `cas_in` equals its identity. Otherwise its state and outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: acts as slave in cascade, 0: master |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 command port, 1 data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: mask (addr 1) or in-service (addr 0) |
| irq_in | input | 8 | Request lines |
| int_out | output | 1 | Interrupt to processor |
| ack | input | 1 | Acknowledge pulse |
| cas_in | input | 3 | Cascade identity seen by a slave |
| vec_valid | output | 1 | Vector is valid this cycle |
| vector | output | 8 | Base plus winning input number |
| cas_out | output | 3 | Master: input number of the acknowledged slave |

## Verification
Two requests are raised together to check that the lower-numbered one wins and that the other is held back while it is in service. A later lower-numbered request is raised to check that it pre-empts an active one. Edge and level configurations are driven with the same line pattern, and only a dropped line separates them. Configurations with and without the cascade word and the mode word check that the step counter reads each data-port write correctly. A wrong-identity acknowledge on a slave and a slave-bearing input on a master check the two cascade roles. A mask written, wiped by a new configuration and written back checks that the mask restores exactly.

// File: rtl/intc_pkg.sv
package intc_pkg;
    parameter int INTC_N  = 8;
    parameter int INTC_IW = $clog2(INTC_N);

    typedef enum logic [2:0] {
        ST_IDLE, ST_BASE, ST_CASC, ST_MODE, ST_RUN
    } init_st_e;

    typedef struct packed {
        init_st_e          st;
        logic              want_mode;
        logic              single;
        logic              level;
        logic              auto_eoi;
        logic [7:0]        base;
        logic [INTC_N-1:0] casc;
    } cfg_t;

    typedef struct packed {
        logic [INTC_N-1:0] irr;
        logic [INTC_N-1:0] isr;
        logic [INTC_N-1:0] mask;
        logic [INTC_N-1:0] prev;
    } core_t;
endpackage

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/intc_init.sv
module intc_init
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output cfg_t       cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (start) begin
            cfg_d.st        = ST_BASE;
            cfg_d.want_mode = wdata[0];
            cfg_d.single    = wdata[1];
            cfg_d.level     = wdata[3];
            cfg_d.auto_eoi  = 1'b0;
        end else if (data_wr) begin
            case (cfg_q.st)
                ST_BASE: begin
                    cfg_d.base = wdata;
                    if (!cfg_q.single)        cfg_d.st = ST_CASC;
                    else if (cfg_q.want_mode) cfg_d.st = ST_MODE;
                    else                      cfg_d.st = ST_RUN;
                end
                ST_CASC: begin
                    cfg_d.casc = wdata[INTC_N-1:0];
                    cfg_d.st   = cfg_q.want_mode ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    cfg_d.auto_eoi = wdata[1];
                    cfg_d.st       = ST_RUN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slave_mode,
    input  logic               wr_en,
    input  logic               addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [INTC_N-1:0]  irq_in,
    output logic               int_out,
    input  logic               ack,
    input  logic [INTC_IW-1:0] cas_in,
    output logic               vec_valid,
    output logic [7:0]         vector,
    output logic [INTC_IW-1:0] cas_out
);
    localparam int N  = INTC_N;
    localparam int IW = INTC_IW;
    localparam logic [7:0] EOI_CODE = 8'h20;

    cfg_t  cfg;
    core_t core_d, core_q;

    logic          start, data_wr, eoi, run;
    logic          any_r, any_s, eligible, master_casc, id_ok, take;
    logic [IW-1:0] idx_r, idx_s;
    logic [N-1:0]  req, irr_eff, rise;
    logic [N-1:0]  mask_q, isr_q;

    assign start   = wr_en && !addr && wdata[4];
    assign data_wr = wr_en && addr;

    intc_init u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .data_wr (data_wr),
        .wdata   (wdata),
        .cfg     (cfg)
    );

    assign run     = (cfg.st == ST_RUN);
    assign eoi     = run && wr_en && !addr && (wdata == EOI_CODE);
    assign rise    = irq_in & ~core_q.prev;
    assign irr_eff = cfg.level ? irq_in : core_q.irr;
    assign req     = irr_eff & ~core_q.mask;

    intc_prio #(.N(N), .IW(IW)) u_req_pick (
        .bits (req),
        .any  (any_r),
        .idx  (idx_r)
    );

    intc_prio #(.N(N), .IW(IW)) u_isr_pick (
        .bits (core_q.isr),
        .any  (any_s),
        .idx  (idx_s)
    );

    assign eligible    = run && any_r && (!any_s || (idx_r < idx_s));
    assign master_casc = !slave_mode && !cfg.single && cfg.casc[idx_r];
    assign id_ok       = cfg.single || !slave_mode || (cas_in == cfg.casc[IW-1:0]);
    assign take        = ack && eligible && id_ok;

    always_comb begin
        core_d      = core_q;
        core_d.prev = irq_in;
        if (start) begin
            core_d.irr  = '0;
            core_d.isr  = '0;
            core_d.mask = '0;
        end else begin
            if (run && data_wr)  core_d.mask = wdata[N-1:0];
            if (run && !cfg.level) core_d.irr = core_q.irr | rise;
            if (eoi && any_s)    core_d.isr[idx_s] = 1'b0;
            if (take) begin
                if (!cfg.level)    core_d.irr[idx_r] = 1'b0;
                if (!cfg.auto_eoi) core_d.isr[idx_r] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign mask_q    = core_q.mask;
    assign isr_q     = core_q.isr;
    assign int_out   = eligible;
    assign vec_valid = take && !master_casc;
    assign vector    = vec_valid ? (cfg.base + 8'(idx_r)) : 8'h00;
    assign cas_out   = (take && master_casc) ? idx_r : '0;
    assign rdata     = addr ? 8'(core_q.mask) : 8'(core_q.isr);
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
    import intc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               addr,
    input logic [7:0]         wdata,
    input logic               ack,
    input logic               int_out,
    input logic               vec_valid,
    input logic [INTC_IW-1:0] cas_out,
    input logic               run,
    input logic               take,
    input logic [INTC_N-1:0]  mask_q,
    input logic [INTC_N-1:0]  isr_q
);
    p_vec_needs_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (ack && int_out));

    p_quiet_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> !int_out);

    p_casc_no_vector_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_out != '0) |-> !vec_valid);

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && addr) |=> (mask_q == $past(wdata[INTC_N-1:0])));

    p_eoi_clears_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && !addr && wdata == 8'h20 && !ack)
        |=> ($countones(isr_q) + 32'($past(isr_q) != '0)) == $countones($past(isr_q)));

    p_isr_grows_by_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> $countones(isr_q) <= $countones($past(isr_q)) + 1);
endmodule

bind intc_core intc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .ack       (ack),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .cas_out   (cas_out),
    .run       (run),
    .take      (take),
    .mask_q    (mask_q),
    .isr_q     (isr_q)
);

// File: tb/intc_core_tb.sv
`timescale 1ns/1ps
module intc_core_tb;
    logic       clk = 0, rst_n = 0, slave_mode = 0, wr_en = 0, addr = 0, ack = 0;
    logic [7:0] wdata = 0, irq_in = 0, rdata, vector;
    logic [2:0] cas_in = 0, cas_out;
    logic       int_out, vec_valid;
    int checks = 0, bad = 0;
    bit comparing = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    intc_core u_dut (.clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
        .ack(ack), .cas_in(cas_in), .vec_valid(vec_valid), .vector(vector), .cas_out(cas_out));

    // reference model state
    int m_st = 0; bit m_w4, m_single, m_level, m_aeoi;
    logic [7:0] m_base = 0, m_casc = 0, m_irr = 0, m_isr = 0, m_mask = 0, m_prev = 0;
    bit e_int, e_vv, e_take; logic [7:0] e_vec, e_rd; logic [2:0] e_cas; int rw, sw;

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    task automatic model_comb();
        logic [7:0] eff; bit mc, idok;
        eff = m_level ? irq_in : m_irr;
        rw = lowest(eff & ~m_mask);
        sw = lowest(m_isr);
        e_int = (m_st == 4) && rw < 8 && rw < sw;
        mc = e_int && !slave_mode && !m_single && m_casc[rw];
        idok = m_single || !slave_mode || cas_in == m_casc[2:0];
        e_take = ack && e_int && idok;
        e_vv = e_take && !mc;
        e_vec = e_vv ? 8'(m_base + rw) : 8'h00;
        e_cas = (e_take && mc) ? 3'(rw) : 3'd0;
        e_rd = addr ? m_mask : m_isr;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_irr = 0; m_isr = 0; m_mask = 0; m_prev = 0; m_base = 0; m_casc = 0;
            m_aeoi = 0; m_level = 0; m_single = 0; m_w4 = 0;
        end else begin
            bit was_run;
            model_comb();
            was_run = (m_st == 4);
            if (wr_en && !addr && wdata[4]) begin
                m_st = 1; m_w4 = wdata[0]; m_single = wdata[1]; m_level = wdata[3];
                m_aeoi = 0; m_irr = 0; m_isr = 0; m_mask = 0;
            end else begin
                if (wr_en && addr) begin
                    case (m_st)
                        1: begin m_base = wdata; m_st = !m_single ? 2 : (m_w4 ? 3 : 4); end
                        2: begin m_casc = wdata; m_st = m_w4 ? 3 : 4; end
                        3: begin m_aeoi = wdata[1]; m_st = 4; end
                        4: m_mask = wdata;
                        default: ;
                    endcase
                end
                if (was_run && !m_level) m_irr = m_irr | (irq_in & ~m_prev);
                if (was_run && wr_en && !addr && wdata == 8'h20 && sw < 8) m_isr[sw] = 1'b0;
                if (e_take) begin
                    if (!m_level) m_irr[rw] = 1'b0;
                    if (!m_aeoi)  m_isr[rw] = 1'b1;
                end
            end
            m_prev = irq_in;
        end
    end

    task automatic expect8(logic [7:0] got, logic [7:0] exp, string what);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) if (comparing) begin
        model_comb();
        expect8(8'(int_out), 8'(e_int), "int_out");
        expect8(8'(vec_valid), 8'(e_vv), "vec_valid");
        expect8(vector, e_vec, "vector");
        expect8(8'(cas_out), 8'(e_cas), "cas_out");
        expect8(rdata, e_rd, "rdata");
    end

    task automatic step(); @(posedge clk); #1; endtask
    task automatic wr(logic a, logic [7:0] d);
        step(); wr_en = 1; addr = a; wdata = d; step(); wr_en = 0;
    endtask
    task automatic rd(logic a, logic [7:0] exp);
        addr = a; @(negedge clk); expect8(rdata, exp, "read"); step();
    endtask
    task automatic pulse_ack(logic vv, logic [7:0] v);
        ack = 1; @(negedge clk);
        expect8(8'(vec_valid), 8'(vv), "ack valid"); expect8(vector, v, "ack vector");
        step(); ack = 0;
    endtask
    task automatic see_int(logic exp);
        @(negedge clk); expect8(8'(int_out), 8'(exp), "int"); step();
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [7:0] saved;
        // R1: reset state, unconfigured
        irq_in = 8'h01;
        repeat (3) step();
        rst_n = 1; step();
        comparing = 1;
        tag = "R1 reset"; see_int(0); rd(1, 8'h00); irq_in = 0; step();

        // R2 R3: edge mode, single, with mode word
        tag = "R2 init";
        wr(0, 8'h13); see_int(0); wr(1, 8'h40); wr(1, 8'h01);
        tag = "R6 zero mask"; rd(1, 8'h00);
        tag = "R8 edge"; irq_in = 8'h28; step(); see_int(1);
        tag = "R3 vector"; pulse_ack(1, 8'h43);
        tag = "R9 blocked"; see_int(0);
        tag = "R7 isr read"; rd(0, 8'h08);
        irq_in = 0;
        tag = "R8 edge latched"; wr(0, 8'h20); see_int(1);
        tag = "R10 ack"; pulse_ack(1, 8'h45); wr(0, 8'h20);
        tag = "R10 idle ack"; pulse_ack(0, 8'h00); rd(0, 8'h00);

        // R9 preemption, R11 eoi
        tag = "R9 preempt";
        irq_in = 8'h10; step(); pulse_ack(1, 8'h44);
        irq_in = 8'h14; step(); see_int(1); pulse_ack(1, 8'h42);
        tag = "R7 two in service"; rd(0, 8'h14);
        tag = "R11 eoi"; wr(0, 8'h20); rd(0, 8'h10);
        tag = "R11 other cmd"; wr(0, 8'h0B); rd(0, 8'h10);
        wr(0, 8'h20); rd(0, 8'h00); irq_in = 0; step();

        // R6 mask
        tag = "R6 mask";
        wr(1, 8'hFF); irq_in = 8'h02; step(); see_int(0); rd(1, 8'hFF);
        wr(1, 8'h00); see_int(1); pulse_ack(1, 8'h41); wr(0, 8'h20); irq_in = 0; step();

        // R8 level, R2 no mode word
        tag = "R8 level";
        wr(0, 8'h1A); wr(1, 8'h20);
        irq_in = 8'h40; see_int(1); irq_in = 0; see_int(0);
        irq_in = 8'h40; pulse_ack(1, 8'h26); see_int(0); rd(0, 8'h40);
        wr(0, 8'h20); see_int(1); irq_in = 0; see_int(0);

        // R5 automatic eoi
        tag = "R5 auto eoi";
        wr(0, 8'h13); wr(1, 8'h50); wr(1, 8'h1F);
        irq_in = 8'h01; step(); pulse_ack(1, 8'h50); rd(0, 8'h00); irq_in = 0; step();

        // R12 R4 master in cascade
        tag = "R12 master";
        slave_mode = 0;
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        irq_in = 8'h04; step(); see_int(1);
        ack = 1; @(negedge clk); expect8(8'(cas_out), 8'h02, "cas_out"); step(); ack = 0;
        rd(0, 8'h04); irq_in = 8'h44; step(); see_int(0);
        wr(0, 8'h20); rd(0, 8'h00);
        tag = "R4 plain input"; pulse_ack(1, 8'h26); wr(0, 8'h20); irq_in = 0; step();

        // R13 slave identity
        tag = "R13 slave";
        slave_mode = 1;
        wr(0, 8'h11); wr(1, 8'h28); wr(1, 8'h02); wr(1, 8'h01);
        irq_in = 8'h08; step(); cas_in = 3'd5; pulse_ack(0, 8'h00);
        see_int(1); rd(0, 8'h00);
        cas_in = 3'd2; pulse_ack(1, 8'h2B); rd(0, 8'h08);
        wr(0, 8'h20); irq_in = 0; cas_in = 0; step();

        // R6 restore, R1 restart clears
        tag = "R6 restore";
        slave_mode = 0;
        wr(1, 8'hA5); saved = rdata; rd(1, 8'hA5);
        tag = "R1 restart";
        irq_in = 8'h80; step();
        wr(0, 8'h13); see_int(0); rd(1, 8'h00);
        wr(1, 8'h08); rd(1, 8'h00); wr(1, 8'h01);
        tag = "R6 restore"; wr(1, saved); rd(1, 8'hA5); see_int(0);
        irq_in = 0; repeat (3) step();

        comparing = 0;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule